// File: doc/BRIEF.md
# Stream-Tagged Set-Associative Translation Cache

This block is a small set-associative cache of address translations. Each entry carries a stream tag, a substream tag, an address-space tag, a virtual-machine tag, a virtual page and the physical page that the virtual page maps to. A single request channel carries lookups, fills and four kinds of invalidation. A separate response channel returns the result of each lookup. Page-table walking, permission checks and statistics are outside the block.

Each lookup or fill picks its set in one of two ways. In stream mode the set comes from the low index bits of the stream tag XORed with the substream tag. In address mode the set comes from the low bits of the virtual page. The substream invalidation and the address invalidation each touch only the set that their key selects. The stream invalidation must find its stream tag under any substream, so it walks every set, one set per clock. During that walk the block raises `busy` and accepts no requests.

Both channels use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a walk is in progress. It is also low while a lookup response is waiting and `rsp_ready` is low. A response stays valid and unchanged until the edge where `rsp_ready` is high.

Top module: `tlb_stream_cache`

## Requirements
- R1: After reset every entry is invalid, `busy` and `rsp_valid` are low, `req_ready` is high, and any lookup misses.
- R2: A lookup (`req_op`=0) hits only when one valid entry in the indexed set matches all five tags: stream, substream, address space, VM and virtual page. The response is valid on the cycle after acceptance. It carries the stored physical page on a hit and zero on a miss.
- R3: With `req_by_stream`=1 the set index is (sid XOR ssid) mod SETS. With `req_by_stream`=0 it is vpn mod SETS. An entry filled in one mode is seen by a lookup in the other mode only when both formulas give the same set.
- R4: A fill (`req_op`=1) writes the lowest-numbered invalid way of its set.
- R5: A fill into a full set replaces a way chosen by the policy. With ROUND_ROBIN=0 it always replaces the last way. With ROUND_ROBIN=1 it uses a per-set pointer that starts at way 0 and advances on each replacement.
- R6: The substream invalidation (`req_op`=2) clears every way in the (sid XOR ssid) set whose stream and substream tags both match. Entries in other sets are left as they are.
- R7: The stream invalidation (`req_op`=3) clears every entry whose stream tag matches, in every set and for any substream. The walk holds `busy` high for exactly SETS cycles, beginning on the cycle after acceptance. `req_ready` is low for that whole time.
- R8: The address invalidation (`req_op`=4) clears the entries in the vpn-indexed set that match the virtual page, the address-space tag and the VM tag. An entry that differs only in its address-space tag survives.
- R9: The full invalidation (`req_op`=5) clears every entry in one cycle, so the very next lookup misses.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its hit flag and page unchanged and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | 0 lookup, 1 fill, 2 invalidate by substream, 3 invalidate by stream, 4 invalidate by address, 5 invalidate all |
| req_by_stream | input | 1 | Lookup/fill index mode: 1 stream hash, 0 virtual page |
| req_sid | input | SID_W | Stream tag |
| req_ssid | input | SSID_W | Substream tag |
| req_asid | input | ASID_W | Address-space tag |
| req_vmid | input | VMID_W | Virtual-machine tag |
| req_vpn | input | VPN_W | Virtual page |
| req_ppn | input | PPN_W | Physical page written by a fill |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page on a hit, zero on a miss |
| busy | output | 1 | Stream invalidation walk in progress |

## Verification
The index hash is checked exhaustively. Each stream tag is combined with each low virtual page: the entry is filled in stream mode and then looked up in both modes. An address-mode hit is expected exactly when the two set formulas agree, so this shows whether the XOR hash and the page index are right. The replacement tests fill one set past its capacity after a targeted invalidation. The pattern of lookups that survive differs between the lowest-free-way rule, the last-way policy and the round-robin policy, so one stimulus separates all three. The invalidation tests place entries that share a stream tag in several sets, and entries that differ in a single tag in the same set. This shows whether each kind of invalidation clears exactly its own key and scope, and whether the walk lasts the right number of cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP   = 3'd0,
    OP_FILL     = 3'd1,
    OP_INV_SSID = 3'd2,
    OP_INV_SID  = 3'd3,
    OP_INV_VA   = 3'd4,
    OP_INV_ALL  = 3'd5
  } tlb_op_e;
endpackage

// File: rtl/tlb_set_index.sv
module tlb_set_index #(
  parameter int IDX_W = 2
) (
  input  logic             use_stream,
  input  logic [IDX_W-1:0] sid_lo,
  input  logic [IDX_W-1:0] ssid_lo,
  input  logic [IDX_W-1:0] vpn_lo,
  output logic [IDX_W-1:0] idx
);
  // Power-of-two set count: the modulo keeps only the low bits.
  assign idx = use_stream ? (sid_lo ^ ssid_lo) : vpn_lo;
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] repl_way,
  output logic [WAY_W-1:0] way,
  output logic             full
);
  always_comb begin
    full = &valid;
    way  = repl_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) way = WAY_W'(w);
    end
    // A set with a free way must never pick an occupied one.
    if (!full) assert_pick_free_R4: assert (!valid[way]);
  end
endmodule

// File: rtl/tlb_sweep_ctrl.sv
module tlb_sweep_ctrl #(
  parameter int SETS  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] cur_set
);
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_set <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cur_set <= '0;
    end else if (busy) begin
      if (cur_set == LAST_SET) busy <= 1'b0;
      else cur_set <= cur_set + 1'b1;
    end
  end

  assert_walk_begins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cur_set == '0));
  assert_walk_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_set == LAST_SET) |=> !busy);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/tlb_stream_cache.sv
module tlb_stream_cache
  import tlb_pkg::*;
#(
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter int SID_W       = 4,
  parameter int SSID_W      = 4,
  parameter int ASID_W      = 4,
  parameter int VMID_W      = 4,
  parameter int VPN_W       = 8,
  parameter int PPN_W       = 8,
  parameter bit ROUND_ROBIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic              req_by_stream,
  input  logic [SID_W-1:0]  req_sid,
  input  logic [SSID_W-1:0] req_ssid,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VMID_W-1:0] req_vmid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PPN_W-1:0]  req_ppn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              busy
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  tlb_op_e op;
  assign op = tlb_op_e'(req_op);

  // Storage
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SID_W-1:0]  sid_q  [SETS][WAYS];
  logic [SSID_W-1:0] ssid_q [SETS][WAYS];
  logic [ASID_W-1:0] asid_q [SETS][WAYS];
  logic [VMID_W-1:0] vmid_q [SETS][WAYS];
  logic [VPN_W-1:0]  vpn_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];
  logic [SID_W-1:0]  sweep_sid_q;

  logic              rsp_valid_q, rsp_hit_q;
  logic [PPN_W-1:0]  rsp_ppn_q;

  logic              accept;
  logic              use_stream;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cur_set;
  logic [WAY_W-1:0]  repl_way, victim;
  logic              set_full;
  logic              sweep_start;
  logic [WAYS-1:0]   hit_vec, ssid_vec, va_vec, sweep_vec;
  logic [PPN_W-1:0]  hit_ppn;

  assign req_ready   = !busy && (!rsp_valid_q || rsp_ready);
  assign accept      = req_valid && req_ready;
  assign sweep_start = accept && (op == OP_INV_SID);
  // Substream invalidation always hashes the stream tags; address
  // invalidation always uses the page; lookups and fills pick per request.
  assign use_stream  = (op == OP_INV_SSID) || ((op != OP_INV_VA) && req_by_stream);

  tlb_set_index #(.IDX_W(IDX_W)) u_index (
    .use_stream (use_stream),
    .sid_lo     (req_sid[IDX_W-1:0]),
    .ssid_lo    (req_ssid[IDX_W-1:0]),
    .vpn_lo     (req_vpn[IDX_W-1:0]),
    .idx        (idx)
  );

  generate
    if (ROUND_ROBIN) begin : g_repl_rr
      assign repl_way = rr_q[idx];
    end else begin : g_repl_last
      assign repl_way = LAST_WAY;
    end
  endgenerate

  tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .valid    (valid_q[idx]),
    .repl_way (repl_way),
    .way      (victim),
    .full     (set_full)
  );

  tlb_sweep_ctrl #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sweep_start),
    .busy    (busy),
    .cur_set (cur_set)
  );

  // Per-way comparisons in the addressed set and in the walked set
  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      ssid_vec[w]  = valid_q[idx][w] && (sid_q[idx][w] == req_sid)
                     && (ssid_q[idx][w] == req_ssid);
      va_vec[w]    = valid_q[idx][w] && (vpn_q[idx][w] == req_vpn)
                     && (asid_q[idx][w] == req_asid) && (vmid_q[idx][w] == req_vmid);
      hit_vec[w]   = ssid_vec[w] && (vpn_q[idx][w] == req_vpn)
                     && (asid_q[idx][w] == req_asid) && (vmid_q[idx][w] == req_vmid);
      sweep_vec[w] = valid_q[cur_set][w] && (sid_q[cur_set][w] == sweep_sid_q);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_ppn = ppn_q[idx][w];
    end
  end

  // Valid bits and replacement pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (accept) begin
        unique case (op)
          OP_FILL: begin
            valid_q[idx][victim] <= 1'b1;
            if (set_full) rr_q[idx] <= (rr_q[idx] == LAST_WAY) ? '0 : rr_q[idx] + 1'b1;
          end
          OP_INV_SSID: valid_q[idx] <= valid_q[idx] & ~ssid_vec;
          OP_INV_VA:   valid_q[idx] <= valid_q[idx] & ~va_vec;
          OP_INV_ALL:  valid_q <= '0;
          default: ;
        endcase
      end
      if (busy) valid_q[cur_set] <= valid_q[cur_set] & ~sweep_vec;
    end
  end

  // Tag and page storage, written only by fills
  always_ff @(posedge clk) begin
    if (accept && op == OP_FILL) begin
      sid_q[idx][victim]  <= req_sid;
      ssid_q[idx][victim] <= req_ssid;
      asid_q[idx][victim] <= req_asid;
      vmid_q[idx][victim] <= req_vmid;
      vpn_q[idx][victim]  <= req_vpn;
      ppn_q[idx][victim]  <= req_ppn;
    end
    if (sweep_start) sweep_sid_q <= req_sid;
  end

  // Lookup response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_ppn_q   <= '0;
    end else if (accept && op == OP_LOOKUP) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= |hit_vec;
      rsp_ppn_q   <= hit_ppn;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_ppn   = rsp_ppn_q;

  // Where the last fill went, for the placement check below
  logic [IDX_W-1:0] fill_set_q;
  logic [WAY_W-1:0] fill_way_q;
  always_ff @(posedge clk) begin
    fill_set_q <= idx;
    fill_way_q <= victim;
  end

  assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FILL) |=> valid_q[fill_set_q][fill_way_q]);
  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_INV_ALL) |=> (valid_q == '0));
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_ppn)));
  assert_rsp_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_LOOKUP) |=> rsp_valid);
  assert_walk_never_adds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: tb/test_tlb_stream_cache.sv
module test_tlb_stream_cache;
  import tlb_pkg::*;

  localparam int SETS = 4;
  localparam int WAYS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic       req_by_stream = 1'b0;
  logic [3:0] req_sid = '0, req_ssid = '0, req_asid = '0, req_vmid = '0;
  logic [7:0] req_vpn = '0, req_ppn = '0;
  logic       rsp_ready = 1'b1;

  logic       rdy0, rv0, hit0, busy0;
  logic       rdy1, rv1, hit1, busy1;
  logic [7:0] ppn0, ppn1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_stream_cache #(.SETS(SETS), .WAYS(WAYS), .ROUND_ROBIN(1'b0)) i_tlb_stream_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0), .req_op(req_op),
    .req_by_stream(req_by_stream), .req_sid(req_sid), .req_ssid(req_ssid),
    .req_asid(req_asid), .req_vmid(req_vmid), .req_vpn(req_vpn), .req_ppn(req_ppn),
    .rsp_valid(rv0), .rsp_ready(rsp_ready), .rsp_hit(hit0), .rsp_ppn(ppn0), .busy(busy0));

  tlb_stream_cache #(.SETS(SETS), .WAYS(WAYS), .ROUND_ROBIN(1'b1)) i_tlb_stream_cache_rr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1), .req_op(req_op),
    .req_by_stream(req_by_stream), .req_sid(req_sid), .req_ssid(req_ssid),
    .req_asid(req_asid), .req_vmid(req_vmid), .req_vpn(req_vpn), .req_ppn(req_ppn),
    .rsp_valid(rv1), .rsp_ready(rsp_ready), .rsp_hit(hit1), .rsp_ppn(ppn1), .busy(busy1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input tlb_op_e op, input logic mode, input int sid, input int ssid,
                       input int asid, input int vmid, input int vpn, input int ppn);
    @(negedge clk);
    req_op = op; req_by_stream = mode;
    req_sid = 4'(sid); req_ssid = 4'(ssid); req_asid = 4'(asid); req_vmid = 4'(vmid);
    req_vpn = 8'(vpn); req_ppn = 8'(ppn);
    req_valid = 1'b1;
    while (!rdy0) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic fill(input logic mode, input int sid, input int ssid, input int asid,
                      input int vmid, input int vpn, input int ppn);
    issue(OP_FILL, mode, sid, ssid, asid, vmid, vpn, ppn);
  endtask

  // Lookup on both instances; e0/e1 are the expected hits, pg the page on a hit.
  task automatic expect_lk(input string req, input logic mode, input int sid, input int ssid,
                           input int asid, input int vmid, input int vpn,
                           input bit e0, input bit e1, input int pg);
    issue(OP_LOOKUP, mode, sid, ssid, asid, vmid, vpn, 0);
    @(negedge clk);
    chk({req, " rsp_valid"}, int'(rv0 & rv1), 1);
    chk({req, " hit last-way"}, int'(hit0), int'(e0));
    chk({req, " hit round-robin"}, int'(hit1), int'(e1));
    chk({req, " ppn last-way"}, int'(ppn0), e0 ? pg : 0);
    chk({req, " ppn round-robin"}, int'(ppn1), e1 ? pg : 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", int'(rdy0 & rdy1), 1);
    chk("R1 busy", int'(busy0 | busy1), 0);
    chk("R1 rsp_valid", int'(rv0 | rv1), 0);
    expect_lk("R1 empty lookup", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 full-tag match
    fill(1'b1, 2, 1, 3, 4, 8'h40, 8'hAB);
    expect_lk("R2 exact", 1'b1, 2, 1, 3, 4, 8'h40, 1, 1, 8'hAB);
    expect_lk("R2 asid differs", 1'b1, 2, 1, 5, 4, 8'h40, 0, 0, 0);
    expect_lk("R2 vmid differs", 1'b1, 2, 1, 3, 6, 8'h40, 0, 0, 0);
    expect_lk("R2 vpn differs", 1'b1, 2, 1, 3, 4, 8'h44, 0, 0, 0);

    // R3 index sweep: all stream tags against every low page value
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < SETS; v++) begin
        bit same;
        same = ((s ^ 5) % SETS) == (v % SETS);
        issue(OP_INV_ALL, 1'b0, 0, 0, 0, 0, 0, 0);
        fill(1'b1, s, 5, 1, 1, v, s * 4 + v + 1);
        expect_lk("R3 stream mode", 1'b1, s, 5, 1, 1, v, 1, 1, s * 4 + v + 1);
        expect_lk("R3 address mode", 1'b0, s, 5, 1, 1, v, same, same, s * 4 + v + 1);
      end
    end

    // R4 / R5 placement and replacement in set 0
    issue(OP_INV_ALL, 1'b0, 0, 0, 0, 0, 0, 0);
    fill(1'b1, 0, 0, 0, 0, 0, 8'h10);                      // X -> way0
    fill(1'b1, 1, 1, 0, 0, 1, 8'h20);                      // Y -> way1
    issue(OP_INV_SSID, 1'b1, 0, 0, 0, 0, 0, 0);            // drop X
    fill(1'b1, 2, 2, 0, 0, 2, 8'h30);                      // Z -> way0 (R4)
    fill(1'b1, 3, 3, 0, 0, 3, 8'h40);                      // W replaces
    expect_lk("R4 X dropped", 1'b1, 0, 0, 0, 0, 0, 0, 0, 8'h10);
    expect_lk("R5 Y", 1'b1, 1, 1, 0, 0, 1, 0, 1, 8'h20);
    expect_lk("R4 Z in free way", 1'b1, 2, 2, 0, 0, 2, 1, 0, 8'h30);
    expect_lk("R5 W", 1'b1, 3, 3, 0, 0, 3, 1, 1, 8'h40);
    fill(1'b1, 4, 4, 0, 0, 4, 8'h50);                      // V replaces again
    expect_lk("R5 Y second", 1'b1, 1, 1, 0, 0, 1, 0, 0, 8'h20);
    expect_lk("R5 Z second", 1'b1, 2, 2, 0, 0, 2, 1, 0, 8'h30);
    expect_lk("R5 W second", 1'b1, 3, 3, 0, 0, 3, 0, 1, 8'h40);
    expect_lk("R5 V", 1'b1, 4, 4, 0, 0, 4, 1, 1, 8'h50);

    // R6 substream invalidation scope
    issue(OP_INV_ALL, 1'b0, 0, 0, 0, 0, 0, 0);
    fill(1'b1, 3, 1, 0, 0, 10, 8'h11);                     // A set 2
    fill(1'b1, 3, 2, 0, 0, 11, 8'h22);                     // B set 1
    fill(1'b0, 3, 1, 0, 0, 20, 8'h33);                     // C set 0 by page
    fill(1'b1, 4, 0, 0, 0, 12, 8'h44);                     // D set 0
    issue(OP_INV_SSID, 1'b1, 3, 1, 0, 0, 0, 0);
    expect_lk("R6 A cleared", 1'b1, 3, 1, 0, 0, 10, 0, 0, 8'h11);
    expect_lk("R6 B other ssid", 1'b1, 3, 2, 0, 0, 11, 1, 1, 8'h22);
    expect_lk("R6 C other set", 1'b0, 3, 1, 0, 0, 20, 1, 1, 8'h33);
    expect_lk("R6 D other sid", 1'b1, 4, 0, 0, 0, 12, 1, 1, 8'h44);

    // R7 stream invalidation walk
    issue(OP_INV_SID, 1'b0, 3, 0, 0, 0, 0, 0);
    begin
      int n;
      n = 0;
      @(negedge clk);
      chk("R7 req_ready low during walk", int'(rdy0 | rdy1), 0);
      while (busy0 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R7 walk length", n, SETS);
      chk("R7 busy agree", int'(busy1), 0);
    end
    expect_lk("R7 B cleared", 1'b1, 3, 2, 0, 0, 11, 0, 0, 8'h22);
    expect_lk("R7 C cleared", 1'b0, 3, 1, 0, 0, 20, 0, 0, 8'h33);
    expect_lk("R7 D kept", 1'b1, 4, 0, 0, 0, 12, 1, 1, 8'h44);

    // R8 address invalidation
    issue(OP_INV_ALL, 1'b0, 0, 0, 0, 0, 0, 0);
    fill(1'b0, 0, 0, 1, 2, 7, 8'h55);                      // E
    fill(1'b0, 0, 0, 2, 2, 7, 8'h66);                      // F
    issue(OP_INV_VA, 1'b0, 0, 0, 1, 2, 7, 0);
    expect_lk("R8 E cleared", 1'b0, 0, 0, 1, 2, 7, 0, 0, 8'h55);
    expect_lk("R8 F other asid", 1'b0, 0, 0, 2, 2, 7, 1, 1, 8'h66);

    // R9 full invalidation
    fill(1'b1, 1, 0, 0, 0, 1, 8'h71);
    fill(1'b1, 2, 0, 0, 0, 2, 8'h72);
    issue(OP_INV_ALL, 1'b0, 0, 0, 0, 0, 0, 0);
    expect_lk("R9 F gone", 1'b0, 0, 0, 2, 2, 7, 0, 0, 8'h66);
    expect_lk("R9 set1 gone", 1'b1, 1, 0, 0, 0, 1, 0, 0, 8'h71);
    expect_lk("R9 set2 gone", 1'b1, 2, 0, 0, 0, 2, 0, 0, 8'h72);

    // R10 response back-pressure
    fill(1'b1, 6, 1, 0, 0, 9, 8'h99);
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(OP_LOOKUP, 1'b1, 6, 1, 0, 0, 9, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held valid", int'(rv0 & rv1), 1);
      chk("R10 held hit", int'(hit0 & hit1), 1);
      chk("R10 held ppn", int'(ppn0), 8'h99);
      chk("R10 req_ready low", int'(rdy0 | rdy1), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", int'(rv0 | rv1), 0);
    chk("R10 ready again", int'(rdy0 & rdy1), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule